// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Interface

This block is the digital front end of a two-channel 12-bit converter. A host writes 16-bit command frames over a serial link framed by an active-low chip select. Each channel keeps a staging (input) register and an output (DAC) register. A new code can therefore be staged without disturbing the converter, copied across later, or written through to the output in the same frame. The DAC register contents leave the block as parallel words. The analog side is out of scope.

The serial pins, chip select and the shutdown-enable pin are brought into the system clock domain by a synchronizer. Edges of the serial clock are detected in that domain, so the system clock must run at least four times faster than the serial clock. A serial data output, taken from the end of the shift register, supports daisy-chaining. It can be set to change on either edge of the serial clock. A command can also drive a general-purpose logic output and enter software shutdown. Software shutdown only takes effect while the shutdown-enable pin is high. Pulling that pin low wakes the block at once, and the converter codes are the ones held before shutdown.

Top module: `dac_serial_if`

## Requirements
- R1: A frame is decoded on the rising edge of chip select after exactly 16 serial clock rising edges. Bits arrive MSB first: bit 15 is the channel address, bits 14:13 are the control code, bits 12:1 are the 12-bit data word and bit 0 is an ignored trailing bit.
- R2: A frame that ends after 15 or after 17 rising edges changes no register, and the next well-formed frame is decoded normally.
- R3: Control code 01 writes the data word into the addressed input register and leaves both DAC outputs unchanged.
- R4: Control code 11 writes the data word into the addressed input register and the addressed DAC register. The other channel is unchanged.
- R5: Control code 10 writes the addressed input register, then copies both input registers into their DAC registers in the same frame.
- R6: With address 0 and control 00, data bits 11:9 hold an extended opcode. Opcode 001 copies both input registers into the DAC registers.
- R7: While chip select is high, serial clock edges shift nothing, do not move the data output, and do not count toward the next frame.
- R8: Extended opcode 101 selects output mode 0 and opcode 110 selects mode 1. In both modes the bit sampled at serial rising edge n appears on the data output after edge n+15. In mode 0 that is a falling edge, and the output holds through the following rising edge. In mode 1 it is a rising edge.
- R9: After reset, both DAC outputs and input registers are zero, the output mode is 0, and the user output, the shutdown flag and the data output are low.
- R10: Extended opcode 100 drives the user output high and opcode 011 drives it low.
- R11: Extended opcode 010 raises the shutdown flag only while the enable pin is high. During shutdown, DAC outputs hold while input registers still accept writes. Opcode 111 leaves shutdown.
- R12: Driving the enable pin low drops the shutdown flag without waiting for a clock, and it stays low after the pin returns high. The DAC outputs keep their pre-shutdown values.
- R13: Address 1 with control 00, and extended opcode 000, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low frame select |
| din_i | input | 1 | Serial data in |
| sd_en_i | input | 1 | Shutdown enable; low blocks and wakes from shutdown |
| dout_o | output | 1 | Serial data out for chaining |
| user_o | output | 1 | Command-driven logic output |
| shutdown_o | output | 1 | Shutdown flag |
| dac_o | output | 24 | DAC codes, channel 1 in bits 23:12, channel 0 in bits 11:0 |

## Verification
The bench builds the block with its default parameters: two channels, 12-bit codes and a two-stage synchronizer. The serial clock runs at one eighth of the system clock in each phase. Those parameters make the full command space small enough to walk every control code and every extended opcode on both channels. The bench also sweeps spread data words through each load path. Frame lengths of 15, 16 and 17 edges, shutdown entry and exit under both enable levels, and bit-by-bit data-output timing in both modes are all checked against a model held in the bench.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int DATA_W  = 12;
  localparam int CH_N    = 2;
  localparam int ADDR_W  = 1;
  localparam int CTL_W   = 2;
  localparam int OP_W    = 3;
  localparam int FRAME_W = ADDR_W + CTL_W + DATA_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CTL_W-1:0]  ctl;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef enum logic [CTL_W-1:0] {
    CTL_EXT       = 2'b00,
    CTL_LOAD      = 2'b01,
    CTL_LOAD_UPD  = 2'b10,
    CTL_LOAD_BOTH = 2'b11
  } ctl_e;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 3'd0,
    OP_UPD   = 3'd1,
    OP_SD    = 3'd2,
    OP_UO_LO = 3'd3,
    OP_UO_HI = 3'd4,
    OP_MODE0 = 3'd5,
    OP_MODE1 = 3'd6,
    OP_WAKE  = 3'd7
  } op_e;
endpackage

// File: rtl/dac_if_sync.sv
module dac_if_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[s] <= RST_VAL;
        else         st_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[s] <= RST_VAL;
        else         st_q[s] <= st_q[s-1];
      end
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dac_if_shifter.sv
module dac_if_shifter
  import dac_if_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic cs_n_s_i,
  input  logic din_s_i,
  input  logic mode1_i,
  output logic strobe_o,
  output logic len_ok_o,
  output cmd_t cmd_o,
  output logic dout_o
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic               sclk_d, cs_d;
  logic               rise, fall, sel;
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               dout_q;

  assign sel  = ~cs_n_s_i;
  assign rise = sel & sclk_s_i & ~sclk_d;
  assign fall = sel & ~sclk_s_i & sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s_i;
      cs_d   <= cs_n_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (rise) sr_q <= {sr_q[FRAME_W-2:0], din_s_i};
  end

  // edge count saturates one past a full frame so long frames stay rejected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (cs_n_s_i)                         cnt_q <= '0;
    else if (rise && cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_q <= 1'b0;
    else if (fall) dout_q <= sr_q[FRAME_W-1];
  end

  assign dout_o   = mode1_i ? sr_q[FRAME_W-1] : dout_q;
  assign strobe_o = cs_n_s_i & ~cs_d;
  assign len_ok_o = (cnt_q == CNT_W'(FRAME_W));
  assign cmd_o    = cmd_t'(sr_q[FRAME_W-1:1]);

  assert_idle_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> ($stable(sr_q) && $stable(dout_q)));
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX));
  assert_dout_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(dout_q));
endmodule

// File: rtl/dac_if_regs.sv
module dac_if_regs
  import dac_if_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          strobe_i,
  input  logic                          len_ok_i,
  input  cmd_t                          cmd_i,
  input  logic                          sd_en_s_i,
  output logic [CH_N-1:0][DATA_W-1:0]   dac_o,
  output logic                          mode1_o,
  output logic                          user_o,
  output logic                          sd_o
);
  logic [CH_N-1:0][DATA_W-1:0] in_q, dac_q;
  logic                        act, ext, wr_in, wr_both, upd_all;
  logic                        mode_q, user_q, sd_q;
  op_e                         op;

  assign act     = strobe_i & len_ok_i;
  assign op      = op_e'(cmd_i.data[DATA_W-1 -: OP_W]);
  assign ext     = act && cmd_i.ctl == CTL_EXT && cmd_i.addr == '0;
  assign wr_in   = act && cmd_i.ctl != CTL_EXT;
  assign wr_both = wr_in && cmd_i.ctl == CTL_LOAD_BOTH && !sd_q;
  assign upd_all = !sd_q && ((wr_in && cmd_i.ctl == CTL_LOAD_UPD) || (ext && op == OP_UPD));

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    logic hit;
    assign hit = wr_in && cmd_i.addr == ADDR_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  in_q[i] <= '0;
      else if (hit) in_q[i] <= cmd_i.data;
    end

    // a frame that loads and updates passes its own word straight through
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 dac_q[i] <= '0;
      else if (upd_all)            dac_q[i] <= hit ? cmd_i.data : in_q[i];
      else if (wr_both && hit)     dac_q[i] <= cmd_i.data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      user_q <= 1'b0;
    end else if (ext) begin
      case (op)
        OP_MODE0: mode_q <= 1'b0;
        OP_MODE1: mode_q <= 1'b1;
        OP_UO_LO: user_q <= 1'b0;
        OP_UO_HI: user_q <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     sd_q <= 1'b0;
    else if (!sd_en_s_i)             sd_q <= 1'b0;
    else if (ext && op == OP_SD)     sd_q <= 1'b1;
    else if (ext && op == OP_WAKE)   sd_q <= 1'b0;
  end

  assign dac_o   = dac_q;
  assign mode1_o = mode_q;
  assign user_o  = user_q;
  assign sd_o    = sd_q;

  assert_sd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_q |=> $stable(dac_q));
  assert_bad_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !len_ok_i) |=> ($stable(in_q) && $stable(dac_q) && $stable(mode_q) && $stable(user_q)));
  assert_lock_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_en_s_i |=> !sd_q);
  assert_load_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && cmd_i.ctl == CTL_LOAD && !sd_q) |=> $stable(dac_q));
  assert_idle_frame_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(in_q) && $stable(dac_q)));
endmodule

// File: rtl/dac_serial_if.sv
module dac_serial_if
  import dac_if_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     cs_ni,
  input  logic                     din_i,
  input  logic                     sd_en_i,
  output logic                     dout_o,
  output logic                     user_o,
  output logic                     shutdown_o,
  output logic [CH_N*DATA_W-1:0]   dac_o
);
  localparam int PIN_N = 4;

  logic [PIN_N-1:0]            pins_s;
  logic                        strobe, len_ok, mode1, sd;
  cmd_t                        cmd;
  logic [CH_N-1:0][DATA_W-1:0] dac_w;

  dac_if_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_N),
    .RST_VAL(4'b1010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sd_en_i, din_i, cs_ni, sclk_i}),
    .q_o   (pins_s)
  );

  dac_if_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(pins_s[0]),
    .cs_n_s_i(pins_s[1]),
    .din_s_i (pins_s[2]),
    .mode1_i (mode1),
    .strobe_o(strobe),
    .len_ok_o(len_ok),
    .cmd_o   (cmd),
    .dout_o  (dout_o)
  );

  dac_if_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .len_ok_i (len_ok),
    .cmd_i    (cmd),
    .sd_en_s_i(pins_s[3]),
    .dac_o    (dac_w),
    .mode1_o  (mode1),
    .user_o   (user_o),
    .sd_o     (sd)
  );

  // raw pin gates the flag so wake-up needs no clock
  assign shutdown_o = sd & sd_en_i;
  assign dac_o      = dac_w;
endmodule

// File: tb/dac_serial_if_tb_top.sv
module dac_serial_if_tb_top;
  localparam int H = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, sd_en = 1'b1;
  logic dout, user, shutdown;
  logic [23:0] dac;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [11:0] in_m [2];
  logic [11:0] dac_m [2];
  logic user_m = 1'b0, sd_m = 1'b0;

  always #2.5 clk = ~clk;

  dac_serial_if dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .din_i(din),
    .sd_en_i(sd_en), .dout_o(dout), .user_o(user), .shutdown_o(shutdown), .dac_o(dac)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] fr(input logic a, input logic [1:0] c, input logic [11:0] d);
    return {a, c, d, 1'b0};
  endfunction

  function automatic logic [15:0] ext(input logic [2:0] op);
    return {3'b000, op, 9'd0, 1'b0};
  endfunction

  // mode: 0 none, 1 check mode 0 timing, 2 check mode 1 timing; prev is the frame before
  task automatic send(input logic [15:0] w, input int nbits, input int mode, input logic [15:0] prev);
    logic [31:0] seq;
    seq = {prev, w};
    cs_n = 1'b0;
    wclk(H);
    for (int k = 1; k <= nbits; k++) begin
      din = (k <= 16) ? w[16-k] : 1'b0;
      wclk(H);
      sclk = 1'b1;
      wclk(H/2);
      if (mode == 2) chk("R8 mode1 after rise", {31'd0, dout}, {31'd0, seq[31-k]});
      if (mode == 1) chk("R8 mode0 hold at rise", {31'd0, dout}, {31'd0, seq[32-k]});
      wclk(H/2);
      sclk = 1'b0;
      wclk(H/2);
      if (mode == 1) chk("R8 mode0 after fall", {31'd0, dout}, {31'd0, seq[31-k]});
      wclk(H/2);
    end
    wclk(H);
    cs_n = 1'b1;
    wclk(2*H);
  endtask

  task automatic chk_state(input string req);
    chk(req, {20'd0, dac[11:0]}, {20'd0, dac_m[0]});
    chk(req, {20'd0, dac[23:12]}, {20'd0, dac_m[1]});
    chk(req, {31'd0, user}, {31'd0, user_m});
    chk(req, {31'd0, shutdown}, {31'd0, sd_m});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    wclk(150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [11:0] v;
    logic        d0;
    for (int c = 0; c < 2; c++) begin
      in_m[c] = '0;
      dac_m[c] = '0;
    end
    wclk(4);
    rst_ni = 1'b1;
    wclk(4);
    chk_state("R9 reset");
    chk("R9 reset dout", {31'd0, dout}, 32'd0);

    // R3 staging sweep, R6 update-all
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 8; k++) begin
        v = 12'(k * 12'h249 + ch * 12'h0f1);
        send(fr(ch[0], 2'b01, v), 16, 0, 16'h0);
        in_m[ch] = v;
        chk_state("R3 load input only");
      end
      send(ext(3'd1), 16, 0, 16'h0);
      dac_m[0] = in_m[0];
      dac_m[1] = in_m[1];
      chk_state("R6 update all");
    end

    // R4 write-through, R1 field positions
    for (int k = 0; k < 8; k++) begin
      v = 12'(12'hfff - k * 12'h1d3);
      send(fr(k[0], 2'b11, v), 16, 0, 16'h0);
      in_m[k[0]] = v;
      dac_m[k[0]] = v;
      chk_state("R4 R1 load both");
    end

    // R5 load then update all
    for (int ch = 0; ch < 2; ch++) begin
      send(fr(~ch[0], 2'b01, 12'h5a5 ^ 12'(ch)), 16, 0, 16'h0);
      in_m[~ch[0]] = 12'h5a5 ^ 12'(ch);
      send(fr(ch[0], 2'b10, 12'h3c3 + 12'(ch)), 16, 0, 16'h0);
      in_m[ch] = 12'h3c3 + 12'(ch);
      dac_m[0] = in_m[0];
      dac_m[1] = in_m[1];
      chk_state("R5 load and update");
    end

    // R2 wrong frame lengths
    send(fr(1'b0, 2'b11, 12'h111), 15, 0, 16'h0);
    chk_state("R2 short frame");
    send(fr(1'b1, 2'b11, 12'h222), 17, 0, 16'h0);
    chk_state("R2 long frame");
    send(fr(1'b1, 2'b11, 12'h333), 16, 0, 16'h0);
    in_m[1] = 12'h333;
    dac_m[1] = 12'h333;
    chk_state("R2 next frame accepted");

    // R7 clock activity with select high
    d0 = dout;
    din = 1'b1;
    for (int k = 0; k < 20; k++) begin
      sclk = 1'b1;
      wclk(H);
      sclk = 1'b0;
      wclk(H);
    end
    din = 1'b0;
    chk("R7 dout idle", {31'd0, dout}, {31'd0, d0});
    chk_state("R7 no action");
    send(fr(1'b0, 2'b11, 12'h0c4), 16, 0, 16'h0);
    in_m[0] = 12'h0c4;
    dac_m[0] = 12'h0c4;
    chk_state("R7 frame after idle clocks");

    // R13 no-ops
    send(fr(1'b1, 2'b00, 12'hfff), 16, 0, 16'h0);
    chk_state("R13 addr1 ctl00");
    send(ext(3'd0), 16, 0, 16'h0);
    chk_state("R13 ext nop");
    send(ext(3'd1), 16, 0, 16'h0);
    chk_state("R13 inputs untouched by nop");

    // R10 user output
    send(ext(3'd4), 16, 0, 16'h0);
    user_m = 1'b1;
    chk_state("R10 user high");
    send(ext(3'd3), 16, 0, 16'h0);
    user_m = 1'b0;
    chk_state("R10 user low");

    // R11 shutdown behaviour
    send(ext(3'd2), 16, 0, 16'h0);
    sd_m = 1'b1;
    chk_state("R11 enter shutdown");
    send(fr(1'b0, 2'b11, 12'h9e7), 16, 0, 16'h0);
    in_m[0] = 12'h9e7;
    chk_state("R11 dac held on write-through");
    send(fr(1'b1, 2'b01, 12'h7e9), 16, 0, 16'h0);
    in_m[1] = 12'h7e9;
    send(ext(3'd1), 16, 0, 16'h0);
    chk_state("R11 update all blocked");
    send(ext(3'd7), 16, 0, 16'h0);
    sd_m = 1'b0;
    chk_state("R11 wake command");
    send(ext(3'd1), 16, 0, 16'h0);
    dac_m[0] = in_m[0];
    dac_m[1] = in_m[1];
    chk_state("R11 inputs kept during shutdown");

    // R12 enable pin wake
    send(ext(3'd2), 16, 0, 16'h0);
    sd_m = 1'b1;
    chk_state("R12 shutdown set");
    sd_en = 1'b0;
    #1;
    chk("R12 immediate wake", {31'd0, shutdown}, 32'd0);
    wclk(10);
    sd_en = 1'b1;
    sd_m = 1'b0;
    wclk(10);
    chk_state("R12 stays awake, codes kept");
    sd_en = 1'b0;
    wclk(10);
    send(ext(3'd2), 16, 0, 16'h0);
    chk_state("R12 shutdown locked out");
    sd_en = 1'b1;
    wclk(10);
    chk_state("R12 lockout release");

    // R8 data output modes
    send(ext(3'd6), 16, 0, 16'h0);
    send(16'h9a5a, 16, 0, 16'h0);
    send(16'h8000, 16, 2, 16'h9a5a);
    send(ext(3'd5), 16, 0, 16'h0);
    send(16'hb3c6, 16, 0, 16'h0);
    send(16'h8000, 16, 1, 16'hb3c6);
    chk_state("R8 data frames inert");

    finish_run();
  end
endmodule